// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Controller

This block makes the control decisions for a six-stage in-order integer pipeline whose stages run fetch, decode, register read, ALU, memory and write-back. Each cycle the stages report what they hold. The block then chooses where each ALU operand comes from, holds the front of the pipe when a load feeds the next instruction, and kills the younger instructions after a taken branch. The register file, ALU, caches and pipeline registers stay outside. The surrounding datapath acts on the select, hold, bubble, kill and redirect outputs.

Operand selection works for the instruction now in the ALU stage. There are three producers, youngest first. The first is the instruction in the memory stage, whose ALU result is latched there. The second is the instruction in the write-back stage. The third is a retired slot, which is a registered copy of whatever was in write-back one cycle earlier. That write landed after the consumer had already read its registers. A load cannot feed the very next instruction, so the block holds the register-read, decode and fetch stages for one cycle and sends a no-op into the ALU stage. A branch resolves in the ALU stage. In the following cycle, while the branch sits in the memory stage, a small two-state machine kills the four younger stages and tells fetch to take the target.

Top module: `hz_ctrl`

## Requirements
- R1: Operand select codes are 0 = register file, 1 = memory-stage result, 2 = write-back-stage result, 3 = retired slot. When the memory-stage instruction writes the register named by an ALU-stage source, that source's select is 1, whatever the older producers hold.
- R2: With no memory-stage match, a source matched by the write-back-stage destination selects 2.
- R3: The retired slot holds the write-back stage's valid bit, write flag and destination from the previous clock edge. With no memory-stage or write-back match, a source matched by the retired slot selects 3.
- R4: A source matched by no producer selects 0. Register 0 never matches, and neither does the destination of an instruction whose write flag is low.
- R5: A stage whose valid bit is low takes part in no match. With an invalid ALU-stage instruction, both selects are 0.
- R6: A valid load in the ALU stage whose destination matches either source of a valid register-read instruction raises hold and bubble in that same cycle.
- R7: A matching non-load in the ALU stage raises neither hold nor bubble.
- R8: A valid taken branch in the ALU stage makes the kill and redirect outputs high for exactly the following cycle. A branch that is not taken, or a taken flag on a non-branch, raises neither.
- R9: During a kill cycle, hold and bubble stay low even when a load-use case is present. A taken branch seen in the ALU stage during a kill cycle starts no further kill.
- R10: After reset the machine is in its run state, kill and redirect are low, and the retired slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_valid | input | 1 | Register-read stage holds an instruction |
| rd_src1 | input | AW | First source in register-read stage |
| rd_src2 | input | AW | Second source in register-read stage |
| alu_valid | input | 1 | ALU stage holds an instruction |
| alu_src1 | input | AW | First source of the ALU-stage instruction |
| alu_src2 | input | AW | Second source of the ALU-stage instruction |
| alu_dest | input | AW | Destination of the ALU-stage instruction |
| alu_wr | input | 1 | ALU-stage instruction writes a register |
| alu_load | input | 1 | ALU-stage instruction is a load |
| alu_branch | input | 1 | ALU-stage instruction is a branch |
| alu_taken | input | 1 | Branch outcome computed in the ALU stage |
| mem_valid | input | 1 | Memory stage holds an instruction |
| mem_dest | input | AW | Memory-stage destination |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| wb_dest | input | AW | Write-back-stage destination |
| wb_wr | input | 1 | Write-back-stage instruction writes a register |
| fwd_a_sel | output | 2 | Select for first ALU operand |
| fwd_b_sel | output | 2 | Select for second ALU operand |
| hold_front | output | 1 | Hold register-read, decode and fetch stages |
| bubble_alu | output | 1 | Load a no-op into the ALU stage |
| kill_young | output | 1 | Turn fetch, decode, register-read and ALU contents into no-ops |
| pc_redirect | output | 1 | Load the branch target into the PC |

## Verification
The bench gives every producer stage the same register at once. A design that searched producers from oldest to youngest would then forward a stale value, and the checks on selects 1 and 2 would catch it. It sends a value through write-back and then presents the consumer one cycle later. A design without the retired slot would fall back to the register file, and one that kept the slot through reset would forward a ghost value. It pairs register 0, producers with the write flag low, and invalid stages with matching specifiers; a design that skipped any qualifier would raise a false forward or hold. It also stacks a load-use case and a second taken branch on top of a kill cycle. A design without kill priority would hold the front during the kill, and one that re-armed from the ALU stage would kill twice.

// File: rtl/hz_pkg.sv
package hz_pkg;

    typedef enum logic [1:0] {
        FW_RF  = 2'd0,
        FW_MEM = 2'd1,
        FW_WB  = 2'd2,
        FW_RET = 2'd3
    } fwd_sel_t;

    typedef enum logic {
        ST_RUN      = 1'b0,
        ST_REDIRECT = 1'b1
    } br_state_t;

    localparam int unsigned NPROD = 3;

endpackage

// File: rtl/hz_match.sv
module hz_match #(
    parameter int unsigned AW = 5
) (
    input  logic          prod_valid,
    input  logic          prod_wr,
    input  logic [AW-1:0] prod_dest,
    input  logic [AW-1:0] cons_src,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = prod_valid && prod_wr && (prod_dest != ZERO_REG) && (prod_dest == cons_src);
    end
endmodule

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
    import hz_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic                     cons_valid,
    input  logic [AW-1:0]            cons_src,
    input  logic [NPROD-1:0]         prod_valid,
    input  logic [NPROD-1:0]         prod_wr,
    input  logic [NPROD-1:0][AW-1:0] prod_dest,
    output fwd_sel_t                 sel
);
    logic [NPROD-1:0] hit;

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        hz_match #(.AW(AW)) u_match (
            .prod_valid (prod_valid[p]),
            .prod_wr    (prod_wr[p]),
            .prod_dest  (prod_dest[p]),
            .cons_src   (cons_src),
            .hit        (hit[p])
        );
    end

    // index 0 is the youngest producer and wins
    always_comb begin
        if (!cons_valid)  sel = FW_RF;
        else if (hit[0])  sel = FW_MEM;
        else if (hit[1])  sel = FW_WB;
        else if (hit[2])  sel = FW_RET;
        else              sel = FW_RF;
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
    parameter int unsigned AW = 5
) (
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_src1,
    input  logic [AW-1:0] rd_src2,
    input  logic          alu_valid,
    input  logic          alu_load,
    input  logic          alu_wr,
    input  logic [AW-1:0] alu_dest,
    output logic          load_use
);
    logic [1:0]          hit;
    logic [1:0][AW-1:0]  srcs;

    assign srcs[0] = rd_src1;
    assign srcs[1] = rd_src2;

    for (genvar s = 0; s < 2; s++) begin : g_src
        hz_match #(.AW(AW)) u_match (
            .prod_valid (alu_valid && alu_load),
            .prod_wr    (alu_wr),
            .prod_dest  (alu_dest),
            .cons_src   (srcs[s]),
            .hit        (hit[s])
        );
    end

    always_comb begin
        load_use = rd_valid && (|hit);
    end
endmodule

// File: rtl/hz_redirect_fsm.sv
module hz_redirect_fsm
    import hz_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      taken_in,
    output br_state_t state,
    output logic      kill,
    output logic      redirect
);
    br_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // next state: a taken branch arms one redirect cycle; the cycle after
    // always returns to run because the ALU stage content is being killed
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:      if (taken_in) state_nx = ST_REDIRECT;
            ST_REDIRECT: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        kill     = 1'b0;
        redirect = 1'b0;
        unique case (state)
            ST_RUN:      ;
            ST_REDIRECT: begin
                kill     = 1'b1;
                redirect = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl
    import hz_pkg::*;
#(
    parameter int unsigned AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_src1,
    input  logic [AW-1:0] rd_src2,
    input  logic          alu_valid,
    input  logic [AW-1:0] alu_src1,
    input  logic [AW-1:0] alu_src2,
    input  logic [AW-1:0] alu_dest,
    input  logic          alu_wr,
    input  logic          alu_load,
    input  logic          alu_branch,
    input  logic          alu_taken,
    input  logic          mem_valid,
    input  logic [AW-1:0] mem_dest,
    input  logic          mem_wr,
    input  logic          wb_valid,
    input  logic [AW-1:0] wb_dest,
    input  logic          wb_wr,
    output logic [1:0]    fwd_a_sel,
    output logic [1:0]    fwd_b_sel,
    output logic          hold_front,
    output logic          bubble_alu,
    output logic          kill_young,
    output logic          pc_redirect
);
    localparam int unsigned NOPS = 2;

    // retired slot: what write-back held one cycle ago
    logic          ret_valid;
    logic          ret_wr;
    logic [AW-1:0] ret_dest;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_valid <= 1'b0;
            ret_wr    <= 1'b0;
            ret_dest  <= '0;
        end else begin
            ret_valid <= wb_valid;
            ret_wr    <= wb_wr;
            ret_dest  <= wb_dest;
        end
    end

    logic [NPROD-1:0]         p_valid;
    logic [NPROD-1:0]         p_wr;
    logic [NPROD-1:0][AW-1:0] p_dest;

    assign p_valid = {ret_valid, wb_valid, mem_valid};
    assign p_wr    = {ret_wr,    wb_wr,    mem_wr};
    assign p_dest  = {ret_dest,  wb_dest,  mem_dest};

    logic [NOPS-1:0][AW-1:0] op_src;
    fwd_sel_t                op_sel [NOPS];

    assign op_src[0] = alu_src1;
    assign op_src[1] = alu_src2;

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hz_fwd_sel #(.AW(AW)) u_sel (
            .cons_valid (alu_valid),
            .cons_src   (op_src[g]),
            .prod_valid (p_valid),
            .prod_wr    (p_wr),
            .prod_dest  (p_dest),
            .sel        (op_sel[g])
        );
    end

    assign fwd_a_sel = op_sel[0];
    assign fwd_b_sel = op_sel[1];

    logic load_use;

    hz_load_use #(.AW(AW)) u_lu (
        .rd_valid  (rd_valid),
        .rd_src1   (rd_src1),
        .rd_src2   (rd_src2),
        .alu_valid (alu_valid),
        .alu_load  (alu_load),
        .alu_wr    (alu_wr),
        .alu_dest  (alu_dest),
        .load_use  (load_use)
    );

    br_state_t br_state;
    logic      kill_w;
    logic      redir_w;

    hz_redirect_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .taken_in (alu_valid && alu_branch && alu_taken),
        .state    (br_state),
        .kill     (kill_w),
        .redirect (redir_w)
    );

    // kill outranks the load-use hold
    always_comb begin
        hold_front  = load_use && (br_state == ST_RUN);
        bubble_alu  = hold_front;
        kill_young  = kill_w;
        pc_redirect = redir_w;
    end
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
    parameter int unsigned AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          alu_valid,
    input logic [AW-1:0] alu_src1,
    input logic [AW-1:0] alu_src2,
    input logic          alu_load,
    input logic          alu_branch,
    input logic          alu_taken,
    input logic          mem_valid,
    input logic [AW-1:0] mem_dest,
    input logic          mem_wr,
    input logic [1:0]    fwd_a_sel,
    input logic [1:0]    fwd_b_sel,
    input logic          hold_front,
    input logic          bubble_alu,
    input logic          kill_young,
    input logic          pc_redirect
);
    p_mem_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && mem_valid && mem_wr && mem_dest != '0 && mem_dest == alu_src1)
        |-> fwd_a_sel == 2'd1);

    p_reg0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_src2 == '0) |-> fwd_b_sel == 2'd0);

    p_idle_alu_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !alu_valid |-> (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0));

    p_hold_needs_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_front |-> (alu_valid && alu_load && bubble_alu));

    p_redirect_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_valid && alu_branch && alu_taken && !kill_young) |=> (kill_young && pc_redirect));

    p_single_kill_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_young |=> !kill_young);

    p_kill_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        kill_young |-> !hold_front);
endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_hz_ctrl.sv
module sim_hz_ctrl;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rd_valid; logic [AW-1:0] rd_src1, rd_src2;
    logic alu_valid; logic [AW-1:0] alu_src1, alu_src2, alu_dest;
    logic alu_wr, alu_load, alu_branch, alu_taken;
    logic mem_valid; logic [AW-1:0] mem_dest; logic mem_wr;
    logic wb_valid; logic [AW-1:0] wb_dest; logic wb_wr;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic hold_front, bubble_alu, kill_young, pc_redirect;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hz_ctrl #(.AW(AW)) u0 (.*);

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        rd_valid = 0; rd_src1 = 0; rd_src2 = 0;
        alu_valid = 0; alu_src1 = 0; alu_src2 = 0; alu_dest = 0;
        alu_wr = 0; alu_load = 0; alu_branch = 0; alu_taken = 0;
        mem_valid = 0; mem_dest = 0; mem_wr = 0;
        wb_valid = 0; wb_dest = 0; wb_wr = 0;
    endtask

    task automatic t_reset();
        @(negedge clk); idle();
        wb_valid = 1; wb_dest = 6; wb_wr = 1;
        @(negedge clk); rst_n = 0;
        @(negedge clk); idle(); rst_n = 1;
        alu_valid = 1; alu_src1 = 6;
        #1;
        chk("R10 retired slot empty", fwd_a_sel, 0);
        chk("R10 kill low", kill_young, 0);
        chk("R10 redirect low", pc_redirect, 0);
        chk("R10 hold low", hold_front, 0);
    endtask

    task automatic t_fwd_mem();
        @(negedge clk); idle();
        alu_valid = 1; alu_src1 = 3; alu_src2 = 7;
        mem_valid = 1; mem_dest = 3; mem_wr = 1;
        wb_valid = 1; wb_dest = 3; wb_wr = 1;
        #1;
        chk("R1 memory stage first", fwd_a_sel, 1);
        chk("R4 unmatched source", fwd_b_sel, 0);
    endtask

    task automatic t_fwd_wb();
        @(negedge clk); idle();
        alu_valid = 1; alu_src2 = 7;
        mem_valid = 1; mem_dest = 7; mem_wr = 0;
        wb_valid = 1; wb_dest = 7; wb_wr = 1;
        #1;
        chk("R2 write-back select", fwd_b_sel, 2);
    endtask

    task automatic t_fwd_ret();
        @(negedge clk); idle();
        wb_valid = 1; wb_dest = 9; wb_wr = 1;
        @(negedge clk); idle();
        alu_valid = 1; alu_src1 = 9;
        #1;
        chk("R3 retired slot select", fwd_a_sel, 3);
        wb_valid = 1; wb_dest = 9; wb_wr = 1;
        #1;
        chk("R2 write-back beats retired", fwd_a_sel, 2);
    endtask

    task automatic t_reg0();
        @(negedge clk); idle();
        alu_valid = 1; alu_src1 = 0; alu_src2 = 12;
        mem_valid = 1; mem_dest = 0; mem_wr = 1;
        wb_valid = 1; wb_dest = 12; wb_wr = 0;
        #1;
        chk("R4 register 0 never matches", fwd_a_sel, 0);
        chk("R4 non-writing producer", fwd_b_sel, 0);
    endtask

    task automatic t_invalid();
        @(negedge clk); idle();
        alu_valid = 1; alu_src1 = 5;
        mem_valid = 0; mem_dest = 5; mem_wr = 1;
        #1;
        chk("R5 invalid producer", fwd_a_sel, 0);
        alu_valid = 0; mem_valid = 1;
        #1;
        chk("R5 invalid consumer", fwd_a_sel, 0);
        idle();
        alu_valid = 0; alu_load = 1; alu_wr = 1; alu_dest = 4;
        rd_valid = 1; rd_src1 = 4;
        #1;
        chk("R5 invalid load no hold", hold_front, 0);
    endtask

    task automatic t_load_use();
        @(negedge clk); idle();
        alu_valid = 1; alu_load = 1; alu_wr = 1; alu_dest = 4;
        rd_valid = 1; rd_src1 = 8; rd_src2 = 4;
        #1;
        chk("R6 load-use hold", hold_front, 1);
        chk("R6 load-use bubble", bubble_alu, 1);
        // stub advances: load to memory stage, no-op in ALU stage
        @(negedge clk); idle();
        mem_valid = 1; mem_dest = 4; mem_wr = 1;
        rd_valid = 1; rd_src1 = 8; rd_src2 = 4;
        #1;
        chk("R6 hold released", hold_front, 0);
        @(negedge clk); idle();
        wb_valid = 1; wb_dest = 4; wb_wr = 1;
        alu_valid = 1; alu_src1 = 8; alu_src2 = 4;
        #1;
        chk("R2 loaded value from write-back", fwd_b_sel, 2);
    endtask

    task automatic t_nonload();
        @(negedge clk); idle();
        alu_valid = 1; alu_load = 0; alu_wr = 1; alu_dest = 4;
        rd_valid = 1; rd_src1 = 4;
        #1;
        chk("R7 non-load no hold", hold_front, 0);
        chk("R7 non-load no bubble", bubble_alu, 0);
        alu_load = 1; alu_dest = 0; rd_src1 = 0;
        #1;
        chk("R4 load to register 0 no hold", hold_front, 0);
    endtask

    task automatic t_branch();
        @(negedge clk); idle();
        alu_valid = 1; alu_branch = 1; alu_taken = 0;
        @(negedge clk); idle();
        alu_valid = 1; alu_branch = 0; alu_taken = 1;
        #1;
        chk("R8 not-taken branch no kill", kill_young, 0);
        @(negedge clk); idle();
        #1;
        chk("R8 taken flag on non-branch", kill_young, 0);
        alu_valid = 1; alu_branch = 1; alu_taken = 1;
        #1;
        chk("R8 no kill in resolve cycle", kill_young, 0);
        @(negedge clk); idle();
        #1;
        chk("R8 kill after taken branch", kill_young, 1);
        chk("R8 redirect after taken branch", pc_redirect, 1);
        @(negedge clk);
        #1;
        chk("R8 kill lasts one cycle", kill_young, 0);
    endtask

    task automatic t_flush_prio();
        @(negedge clk); idle();
        alu_valid = 1; alu_branch = 1; alu_taken = 1;
        @(negedge clk); idle();
        alu_valid = 1; alu_branch = 1; alu_taken = 1;
        alu_load = 1; alu_wr = 1; alu_dest = 11;
        rd_valid = 1; rd_src1 = 11;
        #1;
        chk("R9 kill present", kill_young, 1);
        chk("R9 hold suppressed", hold_front, 0);
        chk("R9 bubble suppressed", bubble_alu, 0);
        @(negedge clk); idle();
        #1;
        chk("R9 killed branch ignored", kill_young, 0);
        chk("R9 no second redirect", pc_redirect, 0);
    endtask

    initial begin
        idle();
        repeat (2) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fwd_mem();
        t_fwd_wb();
        t_fwd_ret();
        t_reg0();
        t_invalid();
        t_load_use();
        t_nonload();
        t_branch();
        t_flush_prio();
        @(negedge clk); idle();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule